// File: doc/BRIEF.md
# Asynchronous Byte-Wide Memory Cycle Controller

This block sits on the synchronous side of a chip and runs single read or write cycles on an external asynchronous parallel memory. That memory has a 13-bit address, 8 data bits and four strobes: a low-active enable, a high-active enable, a low-active write strobe and a low-active output strobe. The host offers one command at a time through a valid/ready handshake. The controller drives the strobes for as many clock cycles as the memory's minimum times require. For a read, it registers the data and raises a one-cycle done pulse. For a write, it raises the same pulse once the cycle has closed.

Every minimum time is given in nanoseconds and rounded up to whole clock cycles when the design is built. A mode input selects the slower identification-space timing: a longer read access, a longer write cycle, and extra address settling before the write strobe falls. When that input drops, a fixed quiet period must pass before the next command is accepted. The data bus is split into an output value, an output enable and an input value. The pad that merges them lies outside this block.

Top module: `abus_cycle_ctrl`

## Requirements
- R1: While reset is held, and just after it, both chip enables are inactive (`memCe1N`=1, `memCe2`=0), `memWeN`=1, `memOeN`=1, `memDqOe`=0, `done`=0 and `reqReady`=1.
- R2: A normal read holds the enables active, `memOeN` low and `memWeN` high. It registers `memDqIn` on the 4th rising edge after acceptance (70 ns at a 20 ns clock). `done` is high for exactly one cycle after that edge, with `rdData` equal to the byte that was captured.
- R3: A normal write holds `memWeN` low for exactly 3 cycles and never lowers `memOeN`. The address stays constant while the enables are active, and `done` follows on the 4th edge after acceptance.
- R4: `memDqOe` is high only while `memWeN` is low and for the one cycle after it rises. During those cycles `memDqOut` equals the accepted write byte.
- R5: `reqReady` stays low while a cycle is in progress, so a waiting request is held off. It is high in the cycle where `done` shows, so the next request is accepted on the following edge.
- R6: With `idMode`=1 at acceptance, a read captures data on the 7th edge (140 ns).
- R7: With `idMode`=1 at acceptance, a write keeps the enables active with `memWeN` high for 4 cycles (70 ns) before `memWeN` falls. `done` follows on the 8th edge.
- R8: When `idMode` falls, `reqReady` stays low for 7 cycles (140 ns). Commands accepted after that use normal timing again.
- R9: `memCe2` is always the complement of `memCe1N`.
- R10: A write cycle leaves `rdData` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low reset |
| idMode | input | 1 | Selects identification-space timing; its falling edge starts the exit wait |
| reqValid | input | 1 | Host command valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Command address |
| reqWdata | input | 8 | Write byte |
| reqReady | output | 1 | Controller idle and able to accept a command |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Byte captured by the last read |
| memAddr | output | 13 | Memory address lines |
| memDqOut | output | 8 | Byte driven toward the memory |
| memDqOe | output | 1 | Enables the data pad driver |
| memDqIn | input | 8 | Byte received from the memory |
| memCe1N | output | 1 | Low-active chip enable |
| memCe2 | output | 1 | High-active chip enable |
| memWeN | output | 1 | Low-active write strobe |
| memOeN | output | 1 | Low-active output strobe |

## Verification
The exit countdown started by a falling `idMode` can overlap an identification-space write that is still in flight. The bench provokes this by dropping `idMode` two cycles into such a write. It then judges three things. The write keeps its long timing, with the strobe falling four cycles in and done on the eighth edge. `reqReady` stays low past done until the countdown ends on the tenth edge. A following normal read returns the written byte.

// File: rtl/abus_pkg.sv
package abus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD
  } cycState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // latch command address and data
    logic capture;  // register the read byte
    logic busSel;   // chip enables active
    logic weOn;     // write strobe active
    logic oeOn;     // output strobe active
    logic dqDrive;  // drive the data pad
  } busStrobe_t;

  function automatic int nsToCyc(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/abus_exit_timer.sv
module abus_exit_timer #(
  parameter int EXIT_CYC = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic idMode,
  output logic exitBusy
);
  import abus_pkg::*;

  localparam int CW = $clog2(maxOf(EXIT_CYC, 1) + 1);
  localparam logic [CW-1:0] LOADV = CW'(EXIT_CYC);

  logic [CW-1:0] cntQ;
  logic          idPrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      idPrevQ <= 1'b0;
    end else begin
      idPrevQ <= idMode;
      if (idPrevQ && !idMode) cntQ <= LOADV;
      else if (cntQ != '0)    cntQ <= cntQ - 1'b1;
    end
  end

  assign exitBusy = (cntQ != '0);

endmodule

// File: rtl/abus_ctrl.sv
module abus_ctrl #(
  parameter int CLK_NS       = 20,
  parameter int RD_ACC_NS    = 70,
  parameter int RD_CYC_NS    = 70,
  parameter int WR_CYC_NS    = 70,
  parameter int WR_PULSE_NS  = 50,
  parameter int WR_AW_NS     = 60,
  parameter int WR_DS_NS     = 30,
  parameter int WR_SA_NS     = 0,
  parameter int ID_RD_NS     = 140,
  parameter int ID_WR_CYC_NS = 140,
  parameter int ID_SA_NS     = 70
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 idMode,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 exitBusy,
  output logic                 reqReady,
  output logic                 done,
  output abus_pkg::busStrobe_t stb
);
  import abus_pkg::*;

  // cycle counts derived from nanosecond limits
  localparam int RD_N = maxOf(1, maxOf(nsToCyc(RD_ACC_NS, CLK_NS), nsToCyc(RD_CYC_NS, CLK_NS)));
  localparam int RD_I = maxOf(1, nsToCyc(ID_RD_NS, CLK_NS));
  localparam int PW   = maxOf(1, maxOf(nsToCyc(WR_PULSE_NS, CLK_NS),
                                       maxOf(nsToCyc(WR_AW_NS, CLK_NS), nsToCyc(WR_DS_NS, CLK_NS))));
  localparam int SU_N = nsToCyc(WR_SA_NS, CLK_NS);
  localparam int SU_I = nsToCyc(ID_SA_NS, CLK_NS);
  localparam int HD_N = maxOf(1, nsToCyc(WR_CYC_NS, CLK_NS) - SU_N - PW);
  localparam int HD_I = maxOf(1, nsToCyc(ID_WR_CYC_NS, CLK_NS) - SU_I - PW);
  localparam int MAXC = maxOf(maxOf(maxOf(RD_N, RD_I), maxOf(PW, maxOf(SU_N, SU_I))), maxOf(HD_N, HD_I));
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [CW-1:0] RD_N_M1 = CW'(RD_N - 1);
  localparam logic [CW-1:0] RD_I_M1 = CW'(RD_I - 1);
  localparam logic [CW-1:0] PW_M1   = CW'(PW - 1);
  localparam logic [CW-1:0] SU_N_M1 = CW'(maxOf(SU_N, 1) - 1);
  localparam logic [CW-1:0] SU_I_M1 = CW'(maxOf(SU_I, 1) - 1);
  localparam logic [CW-1:0] HD_N_M1 = CW'(HD_N - 1);
  localparam logic [CW-1:0] HD_I_M1 = CW'(HD_I - 1);

  cycState_t     stQ, stD;
  logic [CW-1:0] cntQ, cntD;
  logic          idQ, idD;
  logic          doneQ, doneD;
  logic          accept;

  assign reqReady = (stQ == ST_IDLE) && !exitBusy;
  assign accept   = reqReady && reqValid;

  always_comb begin
    stD   = stQ;
    cntD  = cntQ;
    idD   = idQ;
    doneD = 1'b0;
    unique case (stQ)
      ST_IDLE: begin
        if (accept) begin
          idD = idMode;
          if (!reqWrite) begin
            stD  = ST_READ;
            cntD = idMode ? RD_I_M1 : RD_N_M1;
          end else if (idMode && (SU_I > 0)) begin
            stD  = ST_SETUP;
            cntD = SU_I_M1;
          end else if (!idMode && (SU_N > 0)) begin
            stD  = ST_SETUP;
            cntD = SU_N_M1;
          end else begin
            stD  = ST_PULSE;
            cntD = PW_M1;
          end
        end
      end
      ST_READ: begin
        if (cntQ == '0) begin
          stD   = ST_IDLE;
          doneD = 1'b1;
        end else cntD = cntQ - 1'b1;
      end
      ST_SETUP: begin
        if (cntQ == '0) begin
          stD  = ST_PULSE;
          cntD = PW_M1;
        end else cntD = cntQ - 1'b1;
      end
      ST_PULSE: begin
        if (cntQ == '0) begin
          stD  = ST_HOLD;
          cntD = idQ ? HD_I_M1 : HD_N_M1;
        end else cntD = cntQ - 1'b1;
      end
      ST_HOLD: begin
        if (cntQ == '0) begin
          stD   = ST_IDLE;
          doneD = 1'b1;
        end else cntD = cntQ - 1'b1;
      end
      default: stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      cntQ  <= '0;
      idQ   <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      stQ   <= stD;
      cntQ  <= cntD;
      idQ   <= idD;
      doneQ <= doneD;
    end
  end

  assign done        = doneQ;
  assign stb.load    = accept;
  assign stb.capture = (stQ == ST_READ) && (cntQ == '0);
  assign stb.busSel  = (stQ != ST_IDLE);
  assign stb.weOn    = (stQ == ST_PULSE);
  assign stb.oeOn    = (stQ == ST_READ);
  assign stb.dqDrive = (stQ == ST_PULSE) || (stQ == ST_HOLD);

endmodule

// File: rtl/abus_datapath.sv
module abus_datapath #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  abus_pkg::busStrobe_t stb,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    memDqIn,
  output logic [DATA_W-1:0]    rdData,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memDqOut,
  output logic                 memDqOe,
  output logic                 memCe1N,
  output logic                 memCe2,
  output logic                 memWeN,
  output logic                 memOeN
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
    end else begin
      if (stb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (stb.capture) rdQ <= memDqIn;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memDqOe  = stb.dqDrive;
  assign memCe1N  = !stb.busSel;
  assign memCe2   = stb.busSel;
  assign memWeN   = !stb.weOn;
  assign memOeN   = !stb.oeOn;
  assign rdData   = rdQ;

endmodule

// File: rtl/abus_cycle_ctrl.sv
module abus_cycle_ctrl #(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 20,
  parameter int RD_ACC_NS    = 70,
  parameter int RD_CYC_NS    = 70,
  parameter int WR_CYC_NS    = 70,
  parameter int WR_PULSE_NS  = 50,
  parameter int WR_AW_NS     = 60,
  parameter int WR_DS_NS     = 30,
  parameter int WR_SA_NS     = 0,
  parameter int ID_RD_NS     = 140,
  parameter int ID_WR_CYC_NS = 140,
  parameter int ID_SA_NS     = 70,
  parameter int ID_EXIT_NS   = 140
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idMode,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memCe1N,
  output logic              memCe2,
  output logic              memWeN,
  output logic              memOeN
);
  import abus_pkg::*;

  localparam int EXIT_CYC = nsToCyc(ID_EXIT_NS, CLK_NS);

  busStrobe_t stb;
  logic       exitBusy;

  abus_exit_timer #(.EXIT_CYC(EXIT_CYC)) u_exit (
    .clk(clk), .rstN(rstN), .idMode(idMode), .exitBusy(exitBusy)
  );

  abus_ctrl #(
    .CLK_NS(CLK_NS), .RD_ACC_NS(RD_ACC_NS), .RD_CYC_NS(RD_CYC_NS),
    .WR_CYC_NS(WR_CYC_NS), .WR_PULSE_NS(WR_PULSE_NS), .WR_AW_NS(WR_AW_NS),
    .WR_DS_NS(WR_DS_NS), .WR_SA_NS(WR_SA_NS), .ID_RD_NS(ID_RD_NS),
    .ID_WR_CYC_NS(ID_WR_CYC_NS), .ID_SA_NS(ID_SA_NS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .idMode(idMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .exitBusy(exitBusy), .reqReady(reqReady),
    .done(done), .stb(stb)
  );

  abus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDqIn(memDqIn), .rdData(rdData), .memAddr(memAddr), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN),
    .memOeN(memOeN)
  );

endmodule

// File: rtl/abus_cycle_chk.sv
module abus_cycle_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              idMode,
  input logic              reqReady,
  input logic              done,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDqOe,
  input logic              memCe1N,
  input logic              memCe2,
  input logic              memWeN,
  input logic              memOeN
);
  // R3
  oe_held_in_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  // R3
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && $past(!memWeN)) |-> $stable(memAddr));

  // R4
  dq_during_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDqOe);

  // R4
  dq_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> memDqOe);

  // R4
  dq_inside_select_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memCe1N && memCe2));

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    memCe2 |-> !reqReady);

  // R8
  exit_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idMode) |=> !reqReady);

endmodule

bind abus_cycle_ctrl abus_cycle_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .idMode(idMode), .reqReady(reqReady), .done(done),
  .memAddr(memAddr), .memDqOe(memDqOe), .memCe1N(memCe1N), .memCe2(memCe2),
  .memWeN(memWeN), .memOeN(memOeN)
);

// File: tb/abus_cycle_ctrl_tb.sv
module abus_cycle_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        idMode;
  logic        reqValid;
  logic        reqWrite;
  logic [12:0] reqAddr;
  logic [7:0]  reqWdata;
  logic        reqReady;
  logic        done;
  logic [7:0]  rdData;
  logic [12:0] memAddr;
  logic [7:0]  memDqOut;
  logic        memDqOe;
  logic [7:0]  memDqIn;
  logic        memCe1N, memCe2, memWeN, memOeN;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  abus_cycle_ctrl u_dut (
    .clk(clk), .rstN(rstN), .idMode(idMode), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .done(done), .rdData(rdData), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn),
    .memCe1N(memCe1N), .memCe2(memCe2), .memWeN(memWeN), .memOeN(memOeN)
  );

  // memory model: 256 bytes, data valid only once access time has passed
  logic [7:0] mem [0:255];
  int         rdAge;
  logic       rdEn;
  assign rdEn    = !memCe1N && memCe2 && !memOeN && memWeN;
  assign memDqIn = (rdEn && rdAge >= (idMode ? 6 : 3)) ? mem[memAddr[7:0]] : 8'hEE;

  always @(posedge clk) rdAge <= rdEn ? rdAge + 1 : 0;
  always @(posedge memWeN) if (!memCe1N && memCe2) mem[memAddr[7:0]] <= memDqOut;

  // {write, addr[12:0], data}; for reads data is the expected byte
  localparam logic [21:0] VEC [0:9] = '{
    {1'b1, 13'h0005, 8'h3C},
    {1'b1, 13'h1A10, 8'hA5},
    {1'b1, 13'h0FFF, 8'h00},
    {1'b0, 13'h0005, 8'h3C},
    {1'b0, 13'h1A10, 8'hA5},
    {1'b1, 13'h0005, 8'hC3},
    {1'b0, 13'h0FFF, 8'h00},
    {1'b0, 13'h0005, 8'hC3},
    {1'b0, 13'h0022, 8'hFF},
    {1'b0, 13'h1A10, 8'hA5}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic doOp(input bit wr, input logic [12:0] a, input logic [7:0] d,
                      input int expLat, input int expSu, input string tg,
                      output logic [7:0] rd);
    int lat = 0, we = 0, su = 0, dqc = 0;
    bit oeBad = 0, dqBad = 0, addrBad = 0, busyRdy = 0, ceBad = 0;
    logic [7:0] prevRd;
    prevRd = rdData;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    forever begin
      if (done || lat > 40) break;
      if (!memWeN) we++;
      if (wr && memCe2 && memWeN && we == 0) su++;
      if (memDqOe) begin dqc++; if (memDqOut != d) dqBad = 1; end
      if (wr && !memOeN) oeBad = 1;
      if (memCe2 && memAddr != a) addrBad = 1;
      if (reqReady) busyRdy = 1;
      if (memCe2 == memCe1N) ceBad = 1;
      lat++;
      @(negedge clk);
    end
    chk(lat == expLat, {tg, " cycle length"}, lat, expLat);
    chk(!addrBad, "R3 address stable", addrBad, 0);
    chk(!busyRdy, "R5 ready low while busy", busyRdy, 0);
    chk(!ceBad, "R9 enable pair", ceBad, 0);
    chk(reqReady, "R5 ready at done", reqReady, 1);
    if (wr) begin
      chk(we == 3, "R3 write strobe width", we, 3);
      chk(!oeBad, "R3 output strobe off", oeBad, 0);
      chk(dqc == 4 && !dqBad, "R4 data drive window", dqc, 4);
      chk(su == expSu, "R7 setup before strobe", su, expSu);
      chk(rdData == prevRd, "R10 read data kept", rdData, prevRd);
    end else begin
      chk(dqc == 0, "R4 no drive on read", dqc, 0);
    end
    rd = rdData;
    @(negedge clk);
    chk(!done, "R2 done one cycle", done, 0);
  endtask

  initial begin
    logic [7:0] rd;
    int lows, doneK, readyK, weK;
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
    rdAge = 0;
    rstN = 1'b0; idMode = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    chk(memCe1N && !memCe2 && memWeN && memOeN && !memDqOe && !done,
        "R1 idle pins in reset", {memCe1N, memCe2, memWeN, memOeN, memDqOe, done}, 6'b101100);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady, "R1 ready after reset", reqReady, 1);
    chk(memCe1N && memWeN && memOeN && !memDqOe, "R1 idle pins after reset", 0, 1);

    // vector table, normal timing
    for (int i = 0; i < 10; i++) begin
      doOp(VEC[i][21], VEC[i][20:8], VEC[i][7:0], 4, 0,
           VEC[i][21] ? "R3" : "R2", rd);
      if (!VEC[i][21]) chk(rd == VEC[i][7:0], "R2 read data", rd, VEC[i][7:0]);
    end

    // identification-space timing
    idMode = 1'b1;
    doOp(1'b1, 13'h0042, 8'h5A, 8, 4, "R7", rd);
    doOp(1'b0, 13'h0042, 8'h00, 7, 0, "R6", rd);
    chk(rd == 8'h5A, "R6 read data", rd, 8'h5A);

    // leaving the mode
    idMode = 1'b0;
    lows = 0;
    @(negedge clk);
    while (!reqReady && lows < 30) begin lows++; @(negedge clk); end
    chk(lows == 7, "R8 exit wait", lows, 7);
    doOp(1'b0, 13'h0042, 8'h00, 4, 0, "R8", rd);
    chk(rd == 8'h5A, "R8 normal read after exit", rd, 8'h5A);

    // mode drop during an identification-space write
    idMode = 1'b1;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 13'h0077; reqWdata = 8'h81;
    @(negedge clk);
    reqValid = 1'b0;
    doneK = -1; readyK = -1; weK = -1;
    for (int k = 0; k < 20; k++) begin
      if (done && doneK < 0) doneK = k;
      if (reqReady && readyK < 0) readyK = k;
      if (!memWeN && weK < 0) weK = k;
      if (k == 2) idMode = 1'b0;
      @(negedge clk);
    end
    chk(weK == 4, "R7 strobe after long setup", weK, 4);
    chk(doneK == 8, "R7 long write done", doneK, 8);
    chk(readyK == 10, "R8 ready after overlap", readyK, 10);
    doOp(1'b0, 13'h0077, 8'h00, 4, 0, "R2", rd);
    chk(rd == 8'h81, "R2 read of overlapped write", rd, 8'h81);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule